// File: doc/BRIEF.md
# Core Rail Fault Supervisor

This block watches a digitized core-rail voltage against its programmed target and an external overcurrent flag. It overrides the mode of every PWM output and qualifies the power-good signal. An overvoltage is latched until power-on reset. While the latch is set, the block works as a hysteretic shunt. It forces all outputs low while the rail is above the limit. It releases them to high impedance once the rail has dropped below the limit minus a hysteresis band.

An undervoltage has hysteresis and only removes the power-good qualifier. An overcurrent sends the outputs to high impedance and starts a wait of one soft-start duration, counted in PWM cycle ticks. At the end of that wait the block issues a one-cycle request for a fresh soft-start. All thresholds come from the target code using integer arithmetic, with floor division: limit = t + ⌊15t/100⌋, hysteresis = ⌊2t/100⌋, and undervoltage limit = t − ⌊9t/100⌋.

Top module: `core_fault_supervisor`

## Requirements
- R1: While `por` is high, `out_mode` is 2'b00, `pgood_ok` is 1, `restart_req` is 0, and no fault input has any effect.
- R2: When `vsense` > t+⌊15t/100⌋ at a clock edge, the overvoltage latch sets. After that edge, `out_mode` is 2'b01 (forced low) and `pgood_ok` is 0.
- R3: Once set, the overvoltage latch holds whatever `vsense` does, until `por` is asserted.
- R4: While latched, `out_mode` becomes 2'b10 (high impedance) after an edge with `vsense` + ⌊2t/100⌋ < limit. It becomes 2'b01 after an edge with `vsense` > limit. Between these two points it holds its last value.
- R5: Undervoltage sets after an edge with `vsense` < t−⌊9t/100⌋. It clears after an edge with `vsense` ≥ that limit + ⌊2t/100⌋, and holds between the two. Undervoltage drops only `pgood_ok`; `out_mode` stays 2'b00.
- R6: When `oc_flag` is high at an edge with no overvoltage, the block enters the overcurrent wait. From that edge, `out_mode` is 2'b10 and `pgood_ok` is 0.
- R7: The overcurrent wait ends on the edge that samples the WAIT_TICKS-th `tick` after entry. After that edge, `restart_req` is 1 and `out_mode` is back to 2'b00.
- R8: Overvoltage takes priority over overcurrent. It cancels a running wait, and no `restart_req` is issued while the latch is set.
- R9: `restart_req` is high for exactly one clock cycle per completed wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, active high, asynchronous |
| tick | input | 1 | One-cycle pulse per PWM switching cycle |
| vsense | input | W | Sensed core voltage code |
| vtarget | input | W | Programmed target voltage code |
| oc_flag | input | 1 | Overcurrent detected |
| out_mode | output | 2 | 00 normal, 01 force low, 10 high impedance |
| pgood_ok | output | 1 | Power-good qualifier, 1 when no fault |
| restart_req | output | 1 | One-cycle soft-start restart request |

## Verification
On every cycle, the assertions check the following. The latch never clears on its own. A latched overvoltage never shows normal mode or power-good. An overcurrent wait always shows high impedance. A restart pulse lasts one cycle, coincides with normal mode, and never appears alongside an overvoltage. Only the bench scenarios can show three things. The first is that the thresholds sit at the right codes, which needs a sweep over targets and voltages. The second is that the hysteresis bands hold their state between the two trip points. The third is that the restart comes on exactly the right tick.

// File: rtl/core_fault_supervisor.sv
module core_fault_supervisor #(
  parameter int W          = 8,
  parameter int WAIT_TICKS = 2048
) (
  input  logic         clk,
  input  logic         por,
  input  logic         tick,
  input  logic [W-1:0] vsense,
  input  logic [W-1:0] vtarget,
  input  logic         oc_flag,
  output logic [1:0]   out_mode,
  output logic         pgood_ok,
  output logic         restart_req
);
  localparam int EW = W + 8;
  localparam int CW = $clog2(WAIT_TICKS + 1);
  localparam logic [1:0] M_NORM = 2'b00;
  localparam logic [1:0] M_LOW  = 2'b01;
  localparam logic [1:0] M_HIZ  = 2'b10;

  logic [EW-1:0] t, v, ov_lim, hys, uv_lim;
  logic          ov_hi, ov_lo, uv_set, uv_clr;
  logic          ov_q, shunt_q, uv_q, oc_q;
  logic [CW-1:0] cnt;

  assign t      = EW'(vtarget);
  assign v      = EW'(vsense);
  assign ov_lim = t + (t * EW'(15)) / EW'(100);
  assign hys    = (t * EW'(2)) / EW'(100);
  assign uv_lim = t - (t * EW'(9)) / EW'(100);

  assign ov_hi  = v > ov_lim;
  assign ov_lo  = (v + hys) < ov_lim;
  assign uv_set = v < uv_lim;
  assign uv_clr = v >= (uv_lim + hys);

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      ov_q        <= 1'b0;
      shunt_q     <= 1'b0;
      uv_q        <= 1'b0;
      oc_q        <= 1'b0;
      cnt         <= '0;
      restart_req <= 1'b0;
    end else begin
      if (ov_hi) ov_q <= 1'b1;

      if (ov_hi)      shunt_q <= 1'b1;
      else if (ov_lo) shunt_q <= 1'b0;

      if (uv_set)      uv_q <= 1'b1;
      else if (uv_clr) uv_q <= 1'b0;

      restart_req <= 1'b0;
      if (ov_q || ov_hi) begin
        oc_q <= 1'b0;
        cnt  <= '0;
      end else if (oc_q) begin
        if (tick) begin
          if (cnt == CW'(WAIT_TICKS - 1)) begin
            oc_q        <= 1'b0;
            cnt         <= '0;
            restart_req <= 1'b1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
      end else if (oc_flag) begin
        oc_q <= 1'b1;
        cnt  <= '0;
      end
    end
  end

  assign out_mode = ov_q ? (shunt_q ? M_LOW : M_HIZ) : (oc_q ? M_HIZ : M_NORM);
  assign pgood_ok = !(ov_q || uv_q || oc_q);
endmodule

// File: rtl/core_fault_supervisor_chk.sv
module core_fault_supervisor_chk (
  input logic       clk,
  input logic       por,
  input logic [1:0] out_mode,
  input logic       pgood_ok,
  input logic       restart_req,
  input logic       ov_q,
  input logic       oc_q
);
  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (por)
    ov_q |=> ov_q);

  assert_ov_no_pgood_R2: assert property (@(posedge clk) disable iff (por)
    ov_q |-> !pgood_ok);

  assert_ov_overrides_R4: assert property (@(posedge clk) disable iff (por)
    ov_q |-> (out_mode == 2'b01 || out_mode == 2'b10));

  assert_oc_hiz_R6: assert property (@(posedge clk) disable iff (por)
    (oc_q && !ov_q) |-> (out_mode == 2'b10 && !pgood_ok));

  assert_restart_normal_R7: assert property (@(posedge clk) disable iff (por)
    restart_req |-> (out_mode == 2'b00 && !oc_q));

  assert_ov_priority_R8: assert property (@(posedge clk) disable iff (por)
    ov_q |-> (!oc_q && !restart_req));

  assert_restart_single_R9: assert property (@(posedge clk) disable iff (por)
    restart_req |=> !restart_req);

  assert_mode_legal_R4: assert property (@(posedge clk) disable iff (por)
    out_mode != 2'b11);
endmodule

bind core_fault_supervisor core_fault_supervisor_chk u_chk (
  .clk(clk), .por(por), .out_mode(out_mode), .pgood_ok(pgood_ok),
  .restart_req(restart_req), .ov_q(ov_q), .oc_q(oc_q)
);

// File: tb/tb_core_fault_supervisor.sv
module tb_core_fault_supervisor;
  localparam int W = 8;
  localparam int WT = 8;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic tick = 1'b0;
  logic [W-1:0] vsense = '0;
  logic [W-1:0] vtarget = '0;
  logic oc_flag = 1'b0;
  logic [1:0] out_mode;
  logic pgood_ok, restart_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  core_fault_supervisor #(.W(W), .WAIT_TICKS(WT)) dut (
    .clk(clk), .por(por), .tick(tick), .vsense(vsense), .vtarget(vtarget),
    .oc_flag(oc_flag), .out_mode(out_mode), .pgood_ok(pgood_ok),
    .restart_req(restart_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic do_por(input int t, input int v);
    nxt(); por = 1'b1; oc_flag = 1'b0; tick = 1'b0;
    nxt(); por = 1'b0; vtarget = W'(t); vsense = W'(v);
  endtask

  task automatic pulse_tick();
    tick = 1'b1; nxt(); tick = 1'b0;
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset holds outputs and masks faults
    vsense = 8'd250; vtarget = 8'd100; oc_flag = 1'b1; tick = 1'b1;
    for (int i = 0; i < 3; i++) begin
      nxt();
      chk("R1 mode", out_mode, 0);
      chk("R1 pgood", pgood_ok, 1);
      chk("R1 restart", restart_req, 0);
    end
    oc_flag = 1'b0; tick = 1'b0;

    // R2, R5: sweep targets and voltages
    for (int ti = 0; ti < 16; ti++) begin
      for (int v = 0; v < 256; v++) begin
        int t, lim, uvl;
        bit ov, uv;
        t = ti * 17;
        lim = t + (t * 15) / 100;
        uvl = t - (t * 9) / 100;
        ov = v > lim;
        uv = v < uvl;
        do_por(t, v);
        nxt();
        chk("R2 sweep mode", out_mode, ov ? 1 : 0);
        chk("R5 sweep pgood", pgood_ok, (ov || uv) ? 0 : 1);
      end
    end

    // R5 undervoltage hysteresis: t=200 limit 182 band 4
    do_por(200, 181); nxt();
    chk("R5 uv set", pgood_ok, 0);
    chk("R5 uv mode", out_mode, 0);
    vsense = 8'd184; nxt();
    chk("R5 uv hold", pgood_ok, 0);
    vsense = 8'd186; nxt();
    chk("R5 uv clear", pgood_ok, 1);
    vsense = 8'd183; nxt();
    chk("R5 no reset inside band", pgood_ok, 1);

    // R2, R3, R4 overvoltage shunt: t=200 limit 230 release below 226
    do_por(200, 231); nxt();
    chk("R2 ov low", out_mode, 1);
    chk("R2 ov pgood", pgood_ok, 0);
    vsense = 8'd228; nxt();
    chk("R4 hold low", out_mode, 1);
    vsense = 8'd225; nxt();
    chk("R4 release hiz", out_mode, 2);
    vsense = 8'd228; nxt();
    chk("R4 hold hiz", out_mode, 2);
    vsense = 8'd231; nxt();
    chk("R4 reclamp", out_mode, 1);
    vsense = 8'd200; nxt(); nxt();
    chk("R3 latch mode", out_mode, 2);
    chk("R3 latch pgood", pgood_ok, 0);
    oc_flag = 1'b1; nxt(); oc_flag = 1'b0;
    for (int k = 0; k < WT + 2; k++) begin
      pulse_tick();
      chk("R8 no restart while latched", restart_req, 0);
    end
    chk("R8 mode while latched", out_mode, 2);
    nxt(); por = 1'b1; nxt(); por = 1'b0; nxt();
    chk("R3 por clears mode", out_mode, 0);
    chk("R3 por clears pgood", pgood_ok, 1);

    // R6, R7, R9 overcurrent wait and restart
    do_por(200, 200);
    oc_flag = 1'b1; nxt(); oc_flag = 1'b0;
    chk("R6 oc mode", out_mode, 2);
    chk("R6 oc pgood", pgood_ok, 0);
    for (int k = 1; k <= WT; k++) begin
      nxt(); nxt();
      pulse_tick();
      if (k < WT) begin
        chk("R7 early restart", restart_req, 0);
        chk("R7 waiting mode", out_mode, 2);
      end else begin
        chk("R7 restart", restart_req, 1);
        chk("R7 mode normal", out_mode, 0);
        chk("R7 pgood back", pgood_ok, 1);
      end
    end
    nxt();
    chk("R9 single pulse", restart_req, 0);

    // R8 overvoltage cancels running wait
    do_por(200, 200);
    oc_flag = 1'b1; nxt(); oc_flag = 1'b0;
    pulse_tick(); pulse_tick();
    vsense = 8'd240; nxt();
    chk("R8 ov over oc", out_mode, 1);
    vsense = 8'd200; nxt();
    for (int k = 0; k < WT + 2; k++) begin
      pulse_tick();
      chk("R8 no restart", restart_req, 0);
    end
    chk("R8 stays shunt hiz", out_mode, 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule